// File: doc/BRIEF.md
# I2C Indirect Register Bridge

This block is an I2C target that answers at one fixed 7-bit bus address (write byte 0x86, read byte 0x87). It lets a bus controller reach a 16-bit register space inside the chip without mapping that space onto the bus. The controller loads a 16-bit internal address into one of two pointer registers. It then moves 16-bit data words through a data register, high byte first. A status register shows whether an internal access is still in flight.

Toward the inside, the bridge drives a single-request port. The request is a level. It stays up with its address, direction and write data held until the internal side returns a one-cycle acknowledge. On a read, that acknowledge carries the returned word. The internal side may need a very long time to answer, so the bridge never guesses a timeout. Instead it holds SCL low, for as long as needed, on any byte that would touch an address or data register while a request is outstanding.

Both bus lines are open drain. The block only ever pulls a line low through its `*_oe` outputs and samples the resolved line level on the inputs. It samples SDA and SCL on the system clock after a synchronizer, so the system clock must run well above the SCL rate.

Top module: `i2c_indirect_bridge`

## Requirements
- R1: An address byte whose upper seven bits equal 1000011 is acknowledged (SDA pulled low in the ninth clock). Any other address byte is not acknowledged, and every later byte is left unacknowledged until the next START.
- R2: A word written to subaddress 0x37 (write pointer) followed by a word written to subaddress 0x38 (data) produces exactly one internal write. That write carries the pointer word as address and the data word as write data, each assembled from high byte then low byte. Reading subaddress 0x37 returns the pointer word.
- R3: A word written to subaddress 0x36 (read pointer) produces one internal read of that address. A following read of subaddress 0x38, done by a repeated START with 0x87, returns the result high byte first, then low byte.
- R4: The word at subaddress 0x35 (status) reads 0x0001 while an internal request is outstanding and 0x0000 once it has been acknowledged. The busy flag is bit 0 of the low byte.
- R5: While a request is outstanding, a byte aimed at subaddress 0x36, 0x37 or 0x38 (subaddress byte or data byte) makes the bridge hold SCL low after that byte's eighth bit until the request is acknowledged, and then release it. A byte aimed at the status subaddress 0x35 is never stretched. SCL is only pulled low while a request is outstanding.
- R6: The internal request stays asserted, with address, direction and write data unchanged, from its issue until the cycle of the acknowledge.
- R7: A subaddress byte other than 0x35..0x38 is not acknowledged, and the bytes that follow it up to the next START are not acknowledged and have no internal effect.
- R8: After the controller answers a read byte with a NAK, the bridge leaves SDA released.
- R9: A START seen in the middle of a byte abandons that byte, and the following bits are taken as a fresh address byte.
- R10: After reset, neither bus line is pulled low and no internal request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or data 0) |
| bk_req | output | 1 | Internal request, held until acknowledged |
| bk_we | output | 1 | 1 write, 0 read |
| bk_addr | output | 16 | Internal address of the request |
| bk_wdata | output | 16 | Write data of the request |
| bk_ack | input | 1 | One-cycle completion from the internal side |
| bk_rdata | input | 16 | Read result, valid with bk_ack |

## Verification
The bus is driven bit by bit by a controller model that honours clock stretching, and it runs against an internal-side model with an adjustable reply delay. The patterns cover several things. Matching and foreign device addresses test the address filter. Valid and unknown subaddresses test subaddress decode. A pointer write followed by a data write, and a pointer read followed by a data read, show that bytes are assembled and ordered correctly in each direction. Status reads taken inside and after a long reply delay show the busy flag rising and falling. Bytes sent to address registers versus the status register while busy separate a stretched ACK from an unstretched one. A START injected after four bits shows that a partial byte is thrown away.

// File: rtl/i2c_brg_pkg.sv
package i2c_brg_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WR,
    ST_RD,
    ST_IGN
  } bus_st_e;

  typedef enum logic [1:0] {
    SEL_RADDR,
    SEL_WADDR,
    SEL_DATA,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic scl_d, sda_d;
  logic scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_brg_regs.sv
module i2c_brg_regs
  import i2c_brg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_lo,
  input  reg_sel_e          wr_sel,
  input  logic [BYTE_W-1:0] wr_byte,
  input  reg_sel_e          rd_sel,
  output logic [WORD_W-1:0] rd_word,
  output logic              busy,
  output logic              bk_req,
  output logic              bk_we,
  output logic [WORD_W-1:0] bk_addr,
  output logic [WORD_W-1:0] bk_wdata,
  input  logic              bk_ack,
  input  logic [WORD_W-1:0] bk_rdata
);
  logic [BYTE_W-1:0] hi_hold;
  logic [WORD_W-1:0] rptr, wptr, rres;
  logic [WORD_W-1:0] word_in;

  assign word_in = {hi_hold, wr_byte};
  assign busy    = bk_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_hold  <= '0;
      rptr     <= '0;
      wptr     <= '0;
      rres     <= '0;
      bk_req   <= 1'b0;
      bk_we    <= 1'b0;
      bk_addr  <= '0;
      bk_wdata <= '0;
    end else begin
      if (bk_req && bk_ack) begin
        bk_req <= 1'b0;
        if (!bk_we) rres <= bk_rdata;
      end
      if (wr_en) begin
        if (!wr_lo) begin
          hi_hold <= wr_byte;
        end else begin
          case (wr_sel)
            SEL_RADDR: begin
              rptr <= word_in;
              if (!bk_req) begin
                bk_req  <= 1'b1;
                bk_we   <= 1'b0;
                bk_addr <= word_in;
              end
            end
            SEL_WADDR: wptr <= word_in;
            SEL_DATA: begin
              if (!bk_req) begin
                bk_req   <= 1'b1;
                bk_we    <= 1'b1;
                bk_addr  <= wptr;
                bk_wdata <= word_in;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_RADDR: rd_word = rptr;
      SEL_WADDR: rd_word = wptr;
      SEL_DATA:  rd_word = rres;
      default:   rd_word = {{(WORD_W-1){1'b0}}, bk_req};
    endcase
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bk_req && !bk_ack) |=> (bk_req && $stable(bk_addr) && $stable(bk_we) && $stable(bk_wdata)));
endmodule

// File: rtl/i2c_indirect_bridge.sv
module i2c_indirect_bridge
  import i2c_brg_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h43,
  parameter logic [BYTE_W-1:0] SA_STAT     = 8'h35,
  parameter logic [BYTE_W-1:0] SA_RADDR    = 8'h36,
  parameter logic [BYTE_W-1:0] SA_WADDR    = 8'h37,
  parameter logic [BYTE_W-1:0] SA_DATA     = 8'h38,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              bk_req,
  output logic              bk_we,
  output logic [WORD_W-1:0] bk_addr,
  output logic [WORD_W-1:0] bk_wdata,
  input  logic              bk_ack,
  input  logic [WORD_W-1:0] bk_rdata
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_DRV  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy;
  logic [WORD_W-1:0] rd_word;

  bus_st_e           state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, tx;
  logic              ack_ok, ack_eval, stat_tgt;
  logic              idx_lo, mack;
  reg_sel_e          sel;
  logic              wr_en, wr_lo;
  logic [BYTE_W-1:0] wr_byte;
  logic [BYTE_W-1:0] rx_full, next_tx;

  function automatic logic sub_valid(input logic [BYTE_W-1:0] b);
    return (b == SA_RADDR) || (b == SA_WADDR) || (b == SA_DATA) || (b == SA_STAT);
  endfunction

  function automatic reg_sel_e sub_decode(input logic [BYTE_W-1:0] b);
    if (b == SA_RADDR)      return SEL_RADDR;
    else if (b == SA_WADDR) return SEL_WADDR;
    else if (b == SA_DATA)  return SEL_DATA;
    else                    return SEL_STAT;
  endfunction

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_brg_regs u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_lo(wr_lo), .wr_sel(sel), .wr_byte(wr_byte),
    .rd_sel(sel), .rd_word(rd_word), .busy(busy),
    .bk_req(bk_req), .bk_we(bk_we), .bk_addr(bk_addr), .bk_wdata(bk_wdata),
    .bk_ack(bk_ack), .bk_rdata(bk_rdata)
  );

  assign rx_full = {shreg[BYTE_W-2:0], sda_s};
  assign next_tx = idx_lo ? rd_word[WORD_W-1 -: BYTE_W] : rd_word[BYTE_W-1:0];

  always_comb begin
    case (state)
      ST_ADDR: ack_eval = (rx_full[BYTE_W-1:1] == DEV_ADDR);
      ST_SUB:  ack_eval = sub_valid(rx_full);
      default: ack_eval = 1'b1;
    endcase
    stat_tgt = (state == ST_SUB) ? (shreg == SA_STAT) : (sel == SEL_STAT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      tx      <= '0;
      ack_ok  <= 1'b0;
      idx_lo  <= 1'b0;
      mack    <= 1'b0;
      sel     <= SEL_STAT;
      wr_en   <= 1'b0;
      wr_lo   <= 1'b0;
      wr_byte <= '0;
      sda_oe  <= 1'b0;
      scl_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (scl_oe && !busy) scl_oe <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WR: begin
            if (scl_rise && cnt <= LAST_BIT) begin
              shreg <= rx_full;
              cnt   <= cnt + 1'b1;
              if (cnt == LAST_BIT) ack_ok <= ack_eval;
            end
            if (scl_fall && cnt == ACK_DRV) begin
              sda_oe <= ack_ok;
              cnt    <= ACK_SLOT;
              if (state != ST_ADDR && busy && !stat_tgt) scl_oe <= 1'b1;
            end
            if (scl_fall && cnt == ACK_SLOT) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              case (state)
                ST_ADDR: begin
                  if (!ack_ok) begin
                    state <= ST_IGN;
                  end else if (shreg[0]) begin
                    state  <= ST_RD;
                    idx_lo <= 1'b0;
                    tx     <= rd_word[WORD_W-1 -: BYTE_W];
                    sda_oe <= ~rd_word[WORD_W-1];
                  end else begin
                    state <= ST_SUB;
                  end
                end
                ST_SUB: begin
                  if (!ack_ok) begin
                    state <= ST_IGN;
                  end else begin
                    state  <= ST_WR;
                    sel    <= sub_decode(shreg);
                    idx_lo <= 1'b0;
                  end
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_lo   <= idx_lo;
                  wr_byte <= shreg;
                  idx_lo  <= ~idx_lo;
                end
              endcase
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              if (cnt <= LAST_BIT) cnt <= cnt + 1'b1;
              else if (cnt == ACK_SLOT) mack <= ~sda_s;
            end
            if (scl_fall) begin
              if (cnt != '0 && cnt <= LAST_BIT) begin
                sda_oe <= ~tx[BYTE_W-2];
                tx     <= {tx[BYTE_W-2:0], 1'b0};
              end else if (cnt == ACK_DRV) begin
                sda_oe <= 1'b0;
                cnt    <= ACK_SLOT;
              end else if (cnt == ACK_SLOT) begin
                if (mack) begin
                  idx_lo <= ~idx_lo;
                  tx     <= next_tx;
                  sda_oe <= ~next_tx[BYTE_W-1];
                  cnt    <= '0;
                end else begin
                  state <= ST_IGN;
                  cnt   <= '0;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  stretch_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> $past(busy));

  // R5
  stretch_release_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_oe && !busy) |=> !scl_oe);

  // R1
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGN || state == ST_IDLE) |-> !sda_oe);

  // R10
  sda_owner_chk: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (state == ST_ADDR || state == ST_SUB || state == ST_WR || state == ST_RD));
endmodule

// File: tb/i2c_indirect_bridge_tb.sv
module i2c_indirect_bridge_tb;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst;
  logic scl_m, sda_m;
  logic scl_oe, sda_oe;
  logic bk_req, bk_we, bk_ack;
  logic [15:0] bk_addr, bk_wdata, bk_rdata;
  wire scl_w = scl_m & ~scl_oe;
  wire sda_w = sda_m & ~sda_oe;

  int errors = 0, checks = 0;
  int bk_delay = 300;
  int wr_cnt = 0, rd_cnt = 0;
  logic [15:0] wr_a, wr_d;
  int last_stretch, ack_stretch;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_indirect_bridge u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .bk_req(bk_req), .bk_we(bk_we), .bk_addr(bk_addr), .bk_wdata(bk_wdata),
    .bk_ack(bk_ack), .bk_rdata(bk_rdata)
  );

  // internal-side model
  initial begin
    int wait_c = 0;
    bk_ack = 1'b0;
    bk_rdata = '0;
    forever begin
      @(negedge clk);
      bk_ack = 1'b0;
      if (bk_req) begin
        if (wait_c >= bk_delay) begin
          bk_ack = 1'b1;
          if (bk_we) begin
            wr_cnt++; wr_a = bk_addr; wr_d = bk_wdata;
          end else begin
            rd_cnt++; bk_rdata = bk_addr ^ 16'hA5C3;
          end
          wait_c = 0;
        end else wait_c++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_high();
    last_stretch = 0;
    scl_m = 1'b1;
    @(negedge clk);
    while (!scl_w) begin
      last_stretch++;
      @(negedge clk);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_high(); q();
    sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_high(); q(); sda_m = 1'b1; q();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; q(); scl_high(); q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; q(); scl_high(); q(); b = sda_w; q(); scl_m = 1'b0; q();
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(a);
    ack_stretch = last_stretch;
    ack = ~a;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(~give_ack);
  endtask

  task automatic wr_reg(input logic [7:0] sub, input logic [15:0] w, output logic ok);
    logic a0, a1, a2, a3;
    bus_start();
    wbyte(8'h86, a0); wbyte(sub, a1); wbyte(w[15:8], a2); wbyte(w[7:0], a3);
    bus_stop();
    ok = a0 & a1 & a2 & a3;
  endtask

  task automatic rd_reg(input logic [7:0] sub, output logic [15:0] w,
                        output int sub_stretch, output logic ok, output logic rel);
    logic a0, a1, a2;
    bus_start();
    wbyte(8'h86, a0); wbyte(sub, a1);
    sub_stretch = ack_stretch;
    bus_start();
    wbyte(8'h87, a2);
    rbyte(1'b1, w[15:8]);
    rbyte(1'b0, w[7:0]);
    repeat (8) @(negedge clk);
    rel = ~sda_oe;
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic wait_idle();
    while (bk_req) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 scl_oe", scl_oe, 0);
    chk("R10 sda_oe", sda_oe, 0);
    chk("R10 bk_req", bk_req, 0);
  endtask

  task automatic t_bad_addr();
    logic a, b;
    int w0 = wr_cnt, r0 = rd_cnt;
    bus_start();
    wbyte(8'h90, a);
    wbyte(8'h37, b);
    bus_stop();
    chk("R1 foreign address nak", a, 0);
    chk("R1 later byte ignored", b, 0);
    chk("R1 no internal access", (wr_cnt - w0) + (rd_cnt - r0), 0);
  endtask

  task automatic t_write();
    logic ok, ok2, rl;
    logic [15:0] w;
    int s, w0;
    bk_delay = 300;
    w0 = wr_cnt;
    wr_reg(8'h37, 16'h1234, ok);
    wr_reg(8'h38, 16'hBEEF, ok2);
    wait_idle();
    chk("R1 address ack on write", ok & ok2, 1);
    chk("R2 one write issued", wr_cnt - w0, 1);
    chk("R2 write address", wr_a, 16'h1234);
    chk("R2 write data", wr_d, 16'hBEEF);
    rd_reg(8'h37, w, s, ok, rl);
    chk("R2 pointer readback", w, 16'h1234);
  endtask

  task automatic t_busy();
    logic ok, rl;
    logic [15:0] w;
    int s;
    bk_delay = 8000;
    wr_reg(8'h37, 16'h2222, ok);
    wr_reg(8'h38, 16'h3333, ok);
    rd_reg(8'h35, w, s, ok, rl);
    chk("R4 status while pending", w, 16'h0001);
    wait_idle();
    rd_reg(8'h35, w, s, ok, rl);
    chk("R4 status after completion", w, 16'h0000);
    chk("R2 delayed write data", wr_d, 16'h3333);
  endtask

  task automatic t_stretch();
    logic ok, a;
    int w0;
    bk_delay = 3000;
    wr_reg(8'h37, 16'h0100, ok);
    w0 = wr_cnt;
    wr_reg(8'h38, 16'h5555, ok);
    bus_start();
    wbyte(8'h86, a);
    wbyte(8'h37, a);
    chk("R5 subaddress byte stretched", (ack_stretch > 500) ? 1 : 0, 1);
    chk("R5 ack after stretch", a, 1);
    chk("R5 request done before release", wr_cnt - w0, 1);
    wbyte(8'h01, a); wbyte(8'h02, a);
    bus_stop();
    wr_reg(8'h38, 16'h6666, ok);
    bus_start();
    wbyte(8'h86, a);
    wbyte(8'h35, a);
    chk("R5 status byte not stretched", ack_stretch, 0);
    bus_stop();
    wait_idle();
    chk("R5 write to new pointer", wr_a, 16'h0102);
  endtask

  task automatic t_read();
    logic ok, rl;
    logic [15:0] w;
    int s, r0;
    bk_delay = 3000;
    r0 = rd_cnt;
    wr_reg(8'h36, 16'h0042, ok);
    rd_reg(8'h38, w, s, ok, rl);
    chk("R3 one read issued", rd_cnt - r0, 1);
    chk("R3 read word high then low", w, 16'h0042 ^ 16'hA5C3);
    chk("R5 data subaddress stretched", (s > 0) ? 1 : 0, 1);
    chk("R1 read address ack", ok, 1);
    chk("R8 sda released after nak", rl, 1);
  endtask

  task automatic t_bad_sub();
    logic a0, a1, a2;
    int w0 = wr_cnt, r0 = rd_cnt;
    bus_start();
    wbyte(8'h86, a0); wbyte(8'h55, a1); wbyte(8'h12, a2);
    bus_stop();
    chk("R7 unknown subaddress nak", a1, 0);
    chk("R7 following byte nak", a2, 0);
    chk("R7 no internal access", (wr_cnt - w0) + (rd_cnt - r0), 0);
  endtask

  task automatic t_restart();
    logic a, ok;
    bk_delay = 300;
    bus_start();
    wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b0);
    bus_start();
    wbyte(8'h86, a);
    chk("R9 fresh address after abort", a, 1);
    wbyte(8'h37, a); wbyte(8'h0F, a); wbyte(8'h0F, a);
    bus_stop();
    wr_reg(8'h38, 16'h1111, ok);
    wait_idle();
    chk("R9 write address after abort", wr_a, 16'h0F0F);
  endtask

  initial begin
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_bad_addr();
    t_write();
    t_busy();
    t_stretch();
    t_read();
    t_bad_sub();
    t_restart();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule